// File: doc/BRIEF.md
# Peripheral-to-Memory DMA Channel with Source Reload

This block is one DMA channel. It copies 32-bit words from a peripheral data register into memory each time the peripheral signals that a word is ready. Software loads a start source address, a start destination address, a transfer count and a set of mode bits in a single configuration write. The channel then waits for peripheral requests. For each one it asks for the bus, waits for the grant, and runs transfers. Each transfer is a read beat followed by a write beat, and each beat completes on an acknowledge.

The source address can be fixed, stepped up or stepped down, and the destination address likewise. In reload mode the source address snaps back to its programmed start after every group of four transfers, so a small ring of peripheral registers can be swept again and again. The destination address keeps advancing through memory the whole time. In burst mode the channel keeps the bus across back-to-back transfers. With reload on, a burst ends and the bus request drops once a group of four is done. When the count runs out, a done flag is set. That flag can raise an interrupt, and it holds the channel stopped until software clears it.

Top module: `dma_reload_chan`

## Requirements
- R1: After synchronous reset, bus_req, done and irq are 0, xfer_cnt is 0, and the channel is disabled: a peripheral request does not raise bus_req.
- R2: Each transfer is a read beat (bus_wr=0) at the current source address, then a write beat (bus_wr=1) at the current destination address. The write beat carries the data returned by the read. A beat stays on the bus until bus_ack is high at a clock edge.
- R3: Step mode field encoding, applied separately to source and destination after each write acknowledge: 2'b00 fixed, 2'b01 plus 4, 2'b10 minus 4, 2'b11 fixed.
- R4: With reload on, the source address returns to its loaded start value after the fourth transfer of every group of four. The destination address keeps stepping.
- R5: With reload off, the source address keeps stepping past the fourth transfer.
- R6: In burst mode, bus_req stays high across back-to-back transfers. It drops after the fourth transfer of a group when reload is on, and after the last transfer when the count reaches zero.
- R7: With burst mode off, each peripheral request produces exactly one transfer, and bus_req drops after it.
- R8: xfer_cnt decrements by one per transfer. The transfer that brings it to zero sets done, and irq equals done AND the interrupt enable.
- R9: While done is set, no transfer starts and bus_req stays low. flag_clr clears done and irq.
- R10: A peripheral request that arrives while a burst is active is held, and it starts the next burst after the current one ends, with no further request needed.
- R11: No bus beat is presented before bus_gnt has been seen high while bus_req is high.
- R12: A configuration load is accepted only while the channel is idle. A load during a transfer changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load all configuration fields (only while idle) |
| cfg_en | input | 1 | Channel enable |
| cfg_ie | input | 1 | Interrupt enable |
| cfg_reload | input | 1 | Source reload every four transfers |
| cfg_burst | input | 1 | Keep the bus across transfers |
| cfg_smode | input | 2 | Source step mode |
| cfg_dmode | input | 2 | Destination step mode |
| cfg_src | input | 32 | Source start address |
| cfg_dst | input | 32 | Destination start address |
| cfg_cnt | input | 16 | Total transfer count |
| flag_clr | input | 1 | Clear the done flag |
| periph_req | input | 1 | Peripheral data-ready request |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | A beat is presented |
| bus_wr | output | 1 | Beat is a write (1) or read (0) |
| bus_addr | output | 32 | Beat address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ack | input | 1 | Beat completes at this edge |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| xfer_cnt | output | 16 | Remaining transfers |
| done | output | 1 | End-of-transfer flag |
| irq | output | 1 | Interrupt request |

## Verification
The write acknowledge that ends a reload group can also be the one that takes the count to zero. In that cycle the source reload, the bus release and the done flag must all take effect together. The bench provokes this with counts that are multiples of four. Separately, it issues a peripheral request in the middle of a burst, so the held request is consumed in the cycle the burst ends. After every write acknowledge, a bench model checks the source, destination, count, bus request and done outputs on the following cycle. It also checks that the held request restarts the bus without any new stimulus.

// File: rtl/dma_reload_chan.sv
module dma_reload_chan #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int GROUP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic          cfg_en,
  input  logic          cfg_ie,
  input  logic          cfg_reload,
  input  logic          cfg_burst,
  input  logic [1:0]    cfg_smode,
  input  logic [1:0]    cfg_dmode,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic          flag_clr,
  input  logic          periph_req,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_valid,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] xfer_cnt,
  output logic          done,
  output logic          irq
);
  localparam int GW = $clog2(GROUP);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  typedef enum logic [1:0] {IDLE, ARB, RD, WR} st_t;
  st_t st;

  logic [AW-1:0] src_q, src0_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;
  logic [GW-1:0] grp_q;
  logic [1:0]    smode_q, dmode_q;
  logic          en_q, ie_q, reload_q, burst_q, pend_q, flag_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m);
    case (m)
      2'b01:   return a + STEP;
      2'b10:   return a - STEP;
      default: return a;
    endcase
  endfunction

  wire start   = (st == IDLE) && !cfg_load && en_q && !flag_q && (cnt_q != '0) && (pend_q || periph_req);
  wire grp_end = reload_q && (grp_q == GW'(GROUP - 1));
  wire last    = (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= IDLE;
      src_q    <= '0;
      src0_q   <= '0;
      dst_q    <= '0;
      cnt_q    <= '0;
      data_q   <= '0;
      grp_q    <= '0;
      smode_q  <= '0;
      dmode_q  <= '0;
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
      reload_q <= 1'b0;
      burst_q  <= 1'b0;
      pend_q   <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      pend_q <= (pend_q || periph_req) && !start;
      if (flag_clr) flag_q <= 1'b0;
      case (st)
        IDLE: begin
          if (cfg_load) begin
            src_q    <= cfg_src;
            src0_q   <= cfg_src;
            dst_q    <= cfg_dst;
            cnt_q    <= cfg_cnt;
            smode_q  <= cfg_smode;
            dmode_q  <= cfg_dmode;
            en_q     <= cfg_en;
            ie_q     <= cfg_ie;
            reload_q <= cfg_reload;
            burst_q  <= cfg_burst;
            grp_q    <= '0;
            pend_q   <= 1'b0;
            flag_q   <= 1'b0;
          end else if (start) begin
            st <= ARB;
          end
        end
        ARB: if (bus_gnt) st <= RD;
        RD: if (bus_ack) begin
          data_q <= bus_rdata;
          st     <= WR;
        end
        WR: if (bus_ack) begin
          src_q <= grp_end ? src0_q : step(src_q, smode_q);
          dst_q <= step(dst_q, dmode_q);
          cnt_q <= cnt_q - CW'(1);
          grp_q <= grp_end ? '0 : grp_q + GW'(1);
          if (last) begin
            flag_q <= 1'b1;
            st     <= IDLE;
          end else if (burst_q && !grp_end) begin
            st <= RD;
          end else begin
            st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign bus_req   = (st != IDLE);
  assign bus_valid = (st == RD) || (st == WR);
  assign bus_wr    = (st == WR);
  assign bus_addr  = bus_wr ? dst_q : src_q;
  assign bus_wdata = data_q;
  assign src_addr  = src_q;
  assign dst_addr  = dst_q;
  assign xfer_cnt  = cnt_q;
  assign done      = flag_q;
  assign irq       = flag_q && ie_q;
endmodule

// File: rtl/dma_reload_chan_chk.sv
module dma_reload_chan_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int GW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_valid,
  input logic          bus_wr,
  input logic          bus_ack,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic [CW-1:0] xfer_cnt,
  input logic          done,
  input logic          reload_q,
  input logic [GW-1:0] grp_q,
  input logic [AW-1:0] src0_q,
  input logic [1:0]    dmode_q
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  wire wack    = bus_valid && bus_wr && bus_ack;
  wire grp_top = reload_q && (grp_q == {GW{1'b1}});

  // R1
  always_ff @(posedge clk)
    if (rst_d && !rst)
      reset_idle_chk: assert (!bus_req && !done && xfer_cnt == '0);

  // R11
  grant_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid) |-> $past(bus_gnt));

  // R4
  reload_src_chk: assert property (@(posedge clk) disable iff (rst)
    wack && grp_top |=> src_addr == $past(src0_q));

  // R6
  burst_release_chk: assert property (@(posedge clk) disable iff (rst)
    wack && grp_top |=> !bus_req);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    wack |=> xfer_cnt == $past(xfer_cnt) - CW'(1));

  // R8
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    wack && xfer_cnt == CW'(1) |=> done);

  // R9
  no_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> !$past(done));

  // R3
  dst_inc_chk: assert property (@(posedge clk) disable iff (rst)
    wack && dmode_q == 2'b01 |=> dst_addr == $past(dst_addr) + AW'(DW / 8));
endmodule

bind dma_reload_chan dma_reload_chan_chk #(.AW(AW), .DW(DW), .CW(CW), .GW(GW)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid),
  .bus_wr(bus_wr), .bus_ack(bus_ack), .src_addr(src_addr), .dst_addr(dst_addr),
  .xfer_cnt(xfer_cnt), .done(done), .reload_q(reload_q), .grp_q(grp_q),
  .src0_q(src0_q), .dmode_q(dmode_q)
);

// File: tb/test_dma_reload_chan.sv
`timescale 1ns/1ps
module test_dma_reload_chan;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        cfg_load = 0, cfg_en = 0, cfg_ie = 0, cfg_reload = 0, cfg_burst = 0;
  logic [1:0]  cfg_smode = 0, cfg_dmode = 0;
  logic [31:0] cfg_src = 0, cfg_dst = 0;
  logic [15:0] cfg_cnt = 0;
  logic        flag_clr = 0, periph_req = 0, bus_gnt = 0, bus_ack = 0;
  logic [31:0] bus_rdata = 0;
  logic        bus_req, bus_valid, bus_wr, done, irq;
  logic [31:0] bus_addr, bus_wdata, src_addr, dst_addr;
  logic [15:0] xfer_cnt;

  dma_reload_chan i_dma_reload_chan (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_en(cfg_en), .cfg_ie(cfg_ie),
    .cfg_reload(cfg_reload), .cfg_burst(cfg_burst), .cfg_smode(cfg_smode),
    .cfg_dmode(cfg_dmode), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
    .flag_clr(flag_clr), .periph_req(periph_req), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_valid(bus_valid), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .src_addr(src_addr), .dst_addr(dst_addr),
    .xfer_cnt(xfer_cnt), .done(done), .irq(irq)
  );

  int checks = 0, fails = 0;
  logic [31:0] m_src, m_src0, m_dst, rdv;
  logic [15:0] m_cnt;
  int          m_grp;
  logic [1:0]  m_sm, m_dm;
  logic        m_rl, m_bu, m_ie, exp_req, exp_done;
  bit          post = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bstep(input logic [31:0] a, input logic [1:0] m);
    if (m == 2'b01) return a + 32'd4;
    if (m == 2'b10) return a - 32'd4;
    return a;
  endfunction

  always @(negedge clk) begin
    if (post) begin
      post = 0;
      chk(src_addr == m_src, "R3 R4 R5 source address", src_addr, m_src);
      chk(dst_addr == m_dst, "R3 R4 destination address", dst_addr, m_dst);
      chk(xfer_cnt == m_cnt, "R8 count", {16'd0, xfer_cnt}, {16'd0, m_cnt});
      chk(bus_req == exp_req, "R6 R7 bus request after transfer", {31'd0, bus_req}, {31'd0, exp_req});
      chk(done == exp_done, "R8 done", {31'd0, done}, {31'd0, exp_done});
      chk(irq == (exp_done && m_ie), "R8 irq", {31'd0, irq}, {31'd0, exp_done && m_ie});
    end
    if (!bus_req) bus_gnt = 0;
    else if (!bus_gnt && ($urandom % 3 == 0)) bus_gnt = 1;
    if (bus_ack) bus_ack = 0;
    else if (bus_valid && ($urandom % 2 == 1)) begin
      chk(bus_gnt, "R11 beat without grant", {31'd0, bus_gnt}, 32'd1);
      if (!bus_wr) begin
        chk(bus_addr == m_src, "R2 read address", bus_addr, m_src);
        rdv = $urandom;
        bus_rdata = rdv;
      end else begin
        chk(bus_addr == m_dst, "R2 write address", bus_addr, m_dst);
        chk(bus_wdata == rdv, "R2 write data", bus_wdata, rdv);
        begin
          bit ge, lst;
          ge = m_rl && (m_grp == 3);
          lst = (m_cnt == 16'd1);
          exp_req = !lst && m_bu && !ge;
          exp_done = lst;
          m_src = ge ? m_src0 : bstep(m_src, m_sm);
          m_dst = bstep(m_dst, m_dm);
          m_cnt = m_cnt - 16'd1;
          m_grp = ge ? 0 : (m_grp + 1) % 4;
        end
        post = 1;
      end
      bus_ack = 1;
    end
  end

  task automatic load(input logic [31:0] s, input logic [31:0] d, input logic [15:0] n,
                      input logic [1:0] sm, input logic [1:0] dm, input bit rl, input bit bu, input bit ie);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_cnt = n; cfg_smode = sm; cfg_dmode = dm;
    cfg_reload = rl; cfg_burst = bu; cfg_ie = ie; cfg_en = 1; cfg_load = 1;
    m_src = s; m_src0 = s; m_dst = d; m_cnt = n; m_sm = sm; m_dm = dm;
    m_rl = rl; m_bu = bu; m_ie = ie; m_grp = 0;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic pulse_req();
    @(negedge clk); periph_req = 1;
    @(negedge clk); periph_req = 0;
  endtask

  task automatic run_to_done();
    for (int g = 0; g < 20000 && !done; g++) begin
      @(negedge clk);
      if (!bus_req) begin
        @(negedge clk);
        if (!bus_req && !done) pulse_req();
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!bus_req, "R1 bus_req after reset", {31'd0, bus_req}, 0);
    chk(!done && !irq, "R1 done/irq after reset", {30'd0, done, irq}, 0);
    chk(xfer_cnt == 0, "R1 count after reset", {16'd0, xfer_cnt}, 0);
    pulse_req();
    repeat (5) @(negedge clk);
    chk(!bus_req, "R1 disabled channel ignores request", {31'd0, bus_req}, 0);

    // reload + burst, decrementing destination; mid-burst request held
    load(32'h0400_0080, 32'h0040_0000, 16, 2'b01, 2'b10, 1, 1, 1);
    pulse_req();
    while (!bus_req) @(negedge clk);
    pulse_req();
    while (bus_req) @(negedge clk);
    begin
      bit seen = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (bus_req) seen = 1;
      end
      chk(seen, "R10 held request restarts burst", {31'd0, seen}, 1);
    end
    run_to_done();
    chk(src_addr == 32'h0400_0080, "R4 source reloaded at end", src_addr, 32'h0400_0080);
    chk(dst_addr == 32'h003F_FFC0, "R4 destination kept stepping", dst_addr, 32'h003F_FFC0);
    chk(done && irq, "R8 done and irq", {30'd0, done, irq}, 3);

    // done blocks new transfers
    pulse_req();
    begin
      bit any = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (bus_req) any = 1;
      end
      chk(!any, "R9 no start while done", {31'd0, any}, 0);
    end
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    chk(!done && !irq, "R9 flag cleared", {30'd0, done, irq}, 0);

    // reload off, burst: one request, bus held through six transfers
    load(32'h0400_0080, 32'h0000_1000, 6, 2'b01, 2'b01, 0, 1, 0);
    pulse_req();
    while (!bus_req) @(negedge clk);
    begin
      bit drop = 0;
      for (int g = 0; g < 2000 && !done; g++) begin
        @(negedge clk);
        if (!bus_req && !done) drop = 1;
      end
      chk(!drop, "R6 bus held until count zero", {31'd0, drop}, 0);
    end
    chk(src_addr == 32'h0400_0098, "R5 source steps past fourth", src_addr, 32'h0400_0098);
    chk(!irq, "R8 irq masked", {31'd0, irq}, 0);

    // single-transfer mode, fixed source
    load(32'h0000_2000, 32'h0000_3000, 3, 2'b00, 2'b01, 0, 0, 1);
    for (int k = 0; k < 3; k++) begin
      pulse_req();
      while (!bus_req) @(negedge clk);
      while (bus_req) @(negedge clk);
    end
    chk(done, "R7 three requests three transfers", {31'd0, done}, 1);
    chk(src_addr == 32'h0000_2000, "R3 fixed source", src_addr, 32'h0000_2000);
    chk(dst_addr == 32'h0000_300C, "R3 incrementing destination", dst_addr, 32'h0000_300C);

    // load during transfer ignored
    load(32'h0000_0100, 32'h0000_0200, 8, 2'b01, 2'b01, 0, 1, 0);
    pulse_req();
    while (!bus_req) @(negedge clk);
    cfg_src = 32'hDEAD_0000; cfg_cnt = 2; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
    run_to_done();
    chk(src_addr == 32'h0000_0120, "R12 load while busy ignored", src_addr, 32'h0000_0120);

    // constrained random rounds
    for (int r = 0; r < 20; r++) begin
      load($urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, 16'(1 + $urandom % 12),
           2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      run_to_done();
      chk(done && (irq == m_ie), "R8 random round end", {30'd0, done, irq}, {30'd0, 1'b1, m_ie});
    end

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
  end
endmodule